// File: doc/BRIEF.md
# Processor Identification Leaf Responder

This block answers processor identification queries. A query carries a 32-bit function number, taken from the accumulator register, and a 32-bit subfunction, taken from the count register. The answer is four 32-bit words, one for each of the accumulator, base, count and data registers. The answers come from two tables held inside the block. The standard table serves function numbers below 0x80000000. The extended table serves function numbers at or above 0x80000000, addressed by the function number minus 0x80000000. A simple write port loads one whole entry (four words) per cycle.

Two answers are adjusted from live state as the query is served. The first is the feature leaf, index 1 in either table. Its data-register bit 9 is cleared whenever the global-enable bit 11 of the interrupt controller base register is clear. The second is standard leaf 0xD, which returns all zeros for a nonzero subfunction while extended-state support is enabled. A request may be presented every cycle, and its answer appears on the response port exactly one cycle later.

Top module: `id_leaf_responder`

## Requirements
- R1: A function number below 0x80000000 whose value is less than STD_DEPTH returns the four words of that standard table entry.
- R2: A function number at or above 0x80000000 whose value minus 0x80000000 is less than EXT_DEPTH returns the four words of that extended table entry.
- R3: A function number whose table index is at or beyond the depth of the table it selects returns zero in all four words.
- R4: For index 1 of either table, bit 9 of the data word (rsp_d) reads 0 when apic_base bit 11 is 0. All other bits are unchanged. When apic_base bit 11 is 1, the stored entry is returned unmodified.
- R5: For standard index 0xD, with xstate_en at 1 and a nonzero subfunction, all four words are zero. With subfunction zero, or with xstate_en at 0, the stored entry is returned.
- R6: rsp_valid is 1 in the cycle after a cycle with req_valid at 1, and 0 otherwise. Without a request, the response words keep their last value.
- R7: A query in the same cycle as a write to the same entry returns the old contents. A later query returns the new contents. A write whose index is at or beyond the selected table's depth has no effect.
- R8: After reset, rsp_valid and all response words are 0, and every table entry reads as zero.
- R9: The subfunction has no effect on any query other than standard index 0xD.
- R10: The write port places wr_leaf bits [31:0] in the accumulator word, [63:32] in the base word, [95:64] in the count word and [127:96] in the data word. wr_ext at 1 selects the extended table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table entry write strobe |
| wr_ext | input | 1 | 1 selects the extended table for the write |
| wr_idx | input | IDX_W | Entry index for the write |
| wr_leaf | input | 128 | Entry contents, data/count/base/accumulator from high to low |
| req_valid | input | 1 | Query present this cycle |
| req_acc | input | 32 | Function number (accumulator) |
| req_cnt | input | 32 | Subfunction (count register) |
| apic_base | input | APIC_W | Interrupt controller base register value |
| xstate_en | input | 1 | Extended-state support enabled |
| rsp_valid | output | 1 | Response words valid |
| rsp_a | output | 32 | Accumulator result word |
| rsp_b | output | 32 | Base result word |
| rsp_c | output | 32 | Count result word |
| rsp_d | output | 32 | Data result word |

## Verification
The bench builds the block with its default parameter values: 16 standard entries and 9 extended entries. With 16 standard entries, standard leaf 0xD lies inside the table, so its subfunction patch can be reached. The uneven extended depth puts the out-of-range boundary at 0x80000009, away from any power of two, and leaves write indices 9 to 15 that must be dropped. Random queries span both tables, the boundaries and the two patched leaves. Random values of the base register and of the extended-state enable are mixed with these queries.

// File: rtl/id_leaf_pkg.sv
package id_leaf_pkg;
    localparam int          WORD_W      = 32;
    localparam logic [31:0] EXT_BASE    = 32'h8000_0000;
    localparam logic [31:0] FEAT_LEAF   = 32'd1;
    localparam logic [31:0] XSTATE_LEAF = 32'd13;
    localparam int          APIC_EN_BIT = 11;
    localparam int          APIC_FT_BIT = 9;

    // Packed so that the accumulator word sits in the low 32 bits.
    typedef struct packed {
        logic [WORD_W-1:0] d;
        logic [WORD_W-1:0] c;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] a;
    } leaf_t;
endpackage

// File: rtl/id_leaf_table.sv
module id_leaf_table
    import id_leaf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  leaf_t            wr_leaf,
    input  logic [31:0]      rd_idx,
    output logic             rd_hit,
    output leaf_t            rd_leaf
);
    localparam logic [31:0] DEPTH_V = 32'(DEPTH);

    leaf_t mem_d [DEPTH];
    leaf_t mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (32'(wr_idx) < DEPTH_V)) begin
            mem_d[wr_idx] = wr_leaf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // Read uses the registered contents, so a same-cycle write is not seen.
    always_comb begin
        rd_hit  = rd_idx < DEPTH_V;
        rd_leaf = '0;
        if (rd_hit) begin
            rd_leaf = mem_q[rd_idx[IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/id_leaf_patch.sv
module id_leaf_patch
    import id_leaf_pkg::*;
#(
    parameter int APIC_W = 64
) (
    input  leaf_t             raw,
    input  logic              hit,
    input  logic              is_ext,
    input  logic [31:0]       idx,
    input  logic [31:0]       sub,
    input  logic [APIC_W-1:0] apic_base,
    input  logic              xstate_en,
    output leaf_t             out
);
    always_comb begin
        out = raw;
        if (!hit) begin
            out = '0;
        end else begin
            if ((idx == FEAT_LEAF) && !apic_base[APIC_EN_BIT]) begin
                out.d[APIC_FT_BIT] = 1'b0;
            end
            if (!is_ext && (idx == XSTATE_LEAF) && xstate_en && (sub != '0)) begin
                out = '0;
            end
        end
    end
endmodule

// File: rtl/id_leaf_responder.sv
module id_leaf_responder
    import id_leaf_pkg::*;
#(
    parameter int STD_DEPTH = 16,
    parameter int EXT_DEPTH = 9,
    parameter int APIC_W    = 64,
    localparam int MAX_DEPTH = (STD_DEPTH > EXT_DEPTH) ? STD_DEPTH : EXT_DEPTH,
    localparam int IDX_W     = (MAX_DEPTH > 2) ? $clog2(MAX_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ext,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [127:0]      wr_leaf,
    input  logic              req_valid,
    input  logic [31:0]       req_acc,
    input  logic [31:0]       req_cnt,
    input  logic [APIC_W-1:0] apic_base,
    input  logic              xstate_en,
    output logic              rsp_valid,
    output logic [31:0]       rsp_a,
    output logic [31:0]       rsp_b,
    output logic [31:0]       rsp_c,
    output logic [31:0]       rsp_d
);
    typedef struct packed {
        logic  vld;
        leaf_t leaf;
    } rsp_state_t;

    rsp_state_t st_d, st_q;

    logic        is_ext;
    logic [31:0] ext_idx, sel_idx;
    logic        std_hit, ext_hit, sel_hit;
    leaf_t       std_leaf, ext_leaf, sel_leaf, patched;
    leaf_t       wr_entry;

    assign wr_entry = leaf_t'(wr_leaf);
    assign is_ext   = req_acc >= EXT_BASE;
    assign ext_idx  = req_acc - EXT_BASE;

    id_leaf_table #(.DEPTH(STD_DEPTH), .IDX_W(IDX_W)) u_std_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && !wr_ext),
        .wr_idx  (wr_idx),
        .wr_leaf (wr_entry),
        .rd_idx  (req_acc),
        .rd_hit  (std_hit),
        .rd_leaf (std_leaf)
    );

    id_leaf_table #(.DEPTH(EXT_DEPTH), .IDX_W(IDX_W)) u_ext_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && wr_ext),
        .wr_idx  (wr_idx),
        .wr_leaf (wr_entry),
        .rd_idx  (ext_idx),
        .rd_hit  (ext_hit),
        .rd_leaf (ext_leaf)
    );

    always_comb begin
        if (is_ext) begin
            sel_hit  = ext_hit;
            sel_leaf = ext_leaf;
            sel_idx  = ext_idx;
        end else begin
            sel_hit  = std_hit;
            sel_leaf = std_leaf;
            sel_idx  = req_acc;
        end
    end

    id_leaf_patch #(.APIC_W(APIC_W)) u_patch (
        .raw       (sel_leaf),
        .hit       (sel_hit),
        .is_ext    (is_ext),
        .idx       (sel_idx),
        .sub       (req_cnt),
        .apic_base (apic_base),
        .xstate_en (xstate_en),
        .out       (patched)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.leaf = patched;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;
    assign rsp_a     = st_q.leaf.a;
    assign rsp_b     = st_q.leaf.b;
    assign rsp_c     = st_q.leaf.c;
    assign rsp_d     = st_q.leaf.d;
endmodule

// File: rtl/id_leaf_checker.sv
module id_leaf_checker #(
    parameter int STD_DEPTH = 16,
    parameter int EXT_DEPTH = 9,
    parameter int APIC_W    = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [31:0]       req_acc,
    input logic [31:0]       req_cnt,
    input logic [APIC_W-1:0] apic_base,
    input logic              xstate_en,
    input logic              rsp_valid,
    input logic [31:0]       rsp_a,
    input logic [31:0]       rsp_b,
    input logic [31:0]       rsp_c,
    input logic [31:0]       rsp_d
);
    logic [127:0] all_words;
    assign all_words = {rsp_d, rsp_c, rsp_b, rsp_a};

    p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(all_words));

    p_std_oor_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_acc[31] && (req_acc >= 32'(STD_DEPTH))) |=> (all_words == '0));

    p_ext_oor_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc[31] && ((req_acc - 32'h8000_0000) >= 32'(EXT_DEPTH)))
        |=> (all_words == '0));

    p_apic_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !apic_base[11] &&
         ((req_acc == 32'd1) || (req_acc == 32'h8000_0001))) |=> !rsp_d[9]);

    p_xstate_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_acc == 32'd13) && xstate_en && (req_cnt != '0))
        |=> (all_words == '0));
endmodule

bind id_leaf_responder id_leaf_checker #(
    .STD_DEPTH (STD_DEPTH),
    .EXT_DEPTH (EXT_DEPTH),
    .APIC_W    (APIC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_acc   (req_acc),
    .req_cnt   (req_cnt),
    .apic_base (apic_base),
    .xstate_en (xstate_en),
    .rsp_valid (rsp_valid),
    .rsp_a     (rsp_a),
    .rsp_b     (rsp_b),
    .rsp_c     (rsp_c),
    .rsp_d     (rsp_d)
);

// File: tb/tb_id_leaf_responder.sv
module tb_id_leaf_responder;
    localparam int CLK_PERIOD = 10;
    localparam int STD_D = 16;
    localparam int EXT_D = 9;
    localparam int IW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_ext = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [127:0]  wr_leaf = '0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_acc = '0, req_cnt = '0;
    logic [63:0]   apic_base = 64'h800;
    logic          xstate_en = 1'b0;
    logic          rsp_valid;
    logic [31:0]   rsp_a, rsp_b, rsp_c, rsp_d;

    int n_cmp = 0;
    int n_bad = 0;

    logic [127:0] std_m [STD_D];
    logic [127:0] ext_m [EXT_D];
    logic [127:0] exp_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    id_leaf_responder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ext(wr_ext), .wr_idx(wr_idx),
        .wr_leaf(wr_leaf), .req_valid(req_valid), .req_acc(req_acc), .req_cnt(req_cnt),
        .apic_base(apic_base), .xstate_en(xstate_en), .rsp_valid(rsp_valid),
        .rsp_a(rsp_a), .rsp_b(rsp_b), .rsp_c(rsp_c), .rsp_d(rsp_d)
    );

    function automatic logic [127:0] model(input logic [31:0] acc, input logic [31:0] cnt);
        logic [127:0] r;
        logic [31:0]  i;
        r = '0;
        if (acc >= 32'h8000_0000) begin
            i = acc - 32'h8000_0000;
            if (i < EXT_D) r = ext_m[i];
        end else begin
            i = acc;
            if (i < STD_D) r = std_m[i];
        end
        if (i == 1 && !apic_base[11]) r[96+9] = 1'b0;
        if (acc == 32'd13 && xstate_en && cnt != 0) r = '0;
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Called at a negedge; one full cycle, sampled at the next negedge.
    task automatic step(input bit rv, input logic [31:0] acc, input logic [31:0] cnt,
                        input bit we, input bit wext, input int widx,
                        input logic [127:0] wl, input string tag);
        req_valid = rv; req_acc = acc; req_cnt = cnt;
        wr_en = we; wr_ext = wext; wr_idx = IW'(widx); wr_leaf = wl;
        if (rv) exp_q = model(acc, cnt);
        @(posedge clk);
        if (we) begin
            if (wext && widx < EXT_D) ext_m[widx] = wl;
            if (!wext && widx < STD_D) std_m[widx] = wl;
        end
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        check({tag, " R6 valid"}, {127'd0, rsp_valid}, {127'd0, rv});
        check(tag, {rsp_d, rsp_c, rsp_b, rsp_a}, exp_q);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < STD_D; i++) std_m[i] = '0;
        for (int i = 0; i < EXT_D; i++) ext_m[i] = '0;
        repeat (3) @(negedge clk);
        check("R8 reset valid", {127'd0, rsp_valid}, 128'd0);
        check("R8 reset words", {rsp_d, rsp_c, rsp_b, rsp_a}, 128'd0);
        rst_n = 1'b1;
        step(1, 32'd3, 0, 0, 0, 0, '0, "R8 empty std table");
        step(1, 32'h8000_0002, 0, 0, 0, 0, '0, "R8 empty ext table");

        // Load both tables; every entry has data bit 9 set (R10 layout).
        for (int i = 0; i < STD_D; i++) step(0, 0, 0, 1, 0, i, rnd128() | (128'h1 << 105), "R10 load std");
        for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 1, i, rnd128() | (128'h1 << 105), "R7 load ext incl dropped");

        apic_base = 64'h800; xstate_en = 1'b0;
        for (int i = 0; i < STD_D; i++) step(1, 32'(i), 0, 0, 0, 0, '0, "R1 std read");
        for (int i = 0; i < EXT_D; i++) step(1, 32'h8000_0000 + 32'(i), 0, 0, 0, 0, '0, "R2 ext read");

        step(1, 32'd16, 0, 0, 0, 0, '0, "R3 std boundary");
        step(1, 32'h7FFF_FFFF, 0, 0, 0, 0, '0, "R3 std top");
        step(1, 32'h8000_0009, 0, 0, 0, 0, '0, "R3 ext boundary");
        step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, '0, "R3 ext top");

        apic_base = 64'h0;
        step(1, 32'd1, 0, 0, 0, 0, '0, "R4 std leaf1 masked");
        step(1, 32'h8000_0001, 0, 0, 0, 0, '0, "R4 ext leaf1 masked");
        step(1, 32'd2, 0, 0, 0, 0, '0, "R4 other leaf unmasked");
        apic_base = 64'hFFFF_FFFF_FFFF_F7FF;
        step(1, 32'd1, 0, 0, 0, 0, '0, "R4 only bit11 matters");
        apic_base = 64'h800;
        step(1, 32'd1, 0, 0, 0, 0, '0, "R4 std leaf1 enabled");

        xstate_en = 1'b1;
        step(1, 32'd13, 32'd1, 0, 0, 0, '0, "R5 xstate sub1");
        step(1, 32'd13, 32'h8000_0000, 0, 0, 0, '0, "R5 xstate sub msb");
        step(1, 32'd13, 32'd0, 0, 0, 0, '0, "R5 xstate sub0");
        xstate_en = 1'b0;
        step(1, 32'd13, 32'd7, 0, 0, 0, '0, "R5 xstate disabled");
        xstate_en = 1'b1;
        step(1, 32'd12, 32'd7, 0, 0, 0, '0, "R9 sub ignored std");
        step(1, 32'h8000_0004, 32'd7, 0, 0, 0, '0, "R9 sub ignored ext");

        step(0, 32'd5, 0, 0, 0, 0, '0, "R6 idle hold");
        step(0, 32'd6, 0, 0, 0, 0, '0, "R6 idle hold again");

        step(1, 32'd4, 0, 1, 0, 4, rnd128(), "R7 same-cycle old");
        step(1, 32'd4, 0, 0, 0, 0, '0, "R7 new after write");
        step(1, 32'h8000_0006, 0, 1, 1, 6, rnd128(), "R7 ext same-cycle old");
        step(1, 32'h8000_0006, 0, 0, 0, 0, '0, "R7 ext new after write");

        for (int n = 0; n < 600; n++) begin
            logic [31:0] acc, cnt;
            int sel;
            sel = int'($urandom % 4);
            case (sel)
                0: acc = $urandom % 20;
                1: acc = 32'h8000_0000 + ($urandom % 12);
                2: acc = $urandom;
                default: acc = (($urandom % 2) != 0 ? 32'h8000_0000 : 32'h0) |
                               (($urandom % 2) != 0 ? 32'd1 : 32'd13);
            endcase
            cnt = (($urandom % 3) == 0) ? 32'd0 : $urandom;
            apic_base = {$urandom, $urandom};
            xstate_en = $urandom % 2 != 0;
            step(($urandom % 5) != 0, acc, cnt, ($urandom % 3) == 0, ($urandom % 2) != 0,
                 int'($urandom % 16), rnd128(), "R1 R2 R3 R4 R5 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule